// File: doc/BRIEF.md
# GPIO Controller with Per-Pin Interrupt Triggers

This block controls up to 32 general-purpose pins through a 32-bit synchronous register bus with separate read and write strobes. Each pin is an input or an output. Output pins drive the matching bit of a value register. Reading the value register returns the synchronized level for input pins and the programmed level for output pins. The pads themselves sit outside the block, so it exposes separate output, output-enable and input vectors.

Every pin has an event detector. Three per-pin configuration bits select the trigger: level or edge, the polarity (high/low level, or rising/falling edge), and an optional any-transition mode. Detected events latch into a raw status register whether or not the pin is enabled. The status is masked by an enable register to give a pending view, and any pending bit raises a single registered interrupt line. Software acknowledges events by writing ones to a clear register. A read-only version register reports whether the any-transition mode is built in.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: During reset and until first written, the value, direction, enable, edge-select, polarity and both-edges registers read 0. pin_oe is all ones, pin_out is 0 and irq is 0. Version (byte offset 0x20) reads the VERSION parameter (default 3). Raw status may latch in the first cycle after reset, because the default trigger is active-low level.
- R2: Direction register (0x04): a 1 makes the pin an input (pin_oe bit 0). A 0 makes it an output (pin_oe bit 1), driven by the matching bit of the value register (0x00) on pin_out. Both take effect the cycle after the write.
- R3: Reading the value register returns, for input pins, pin_in after a two-flop synchronizer, and, for output pins, the written value bit.
- R4: With edge-select (0x18) bit 0, the pin triggers on level: active-high when the polarity bit (0x1C) is 1 and active-low when it is 0. A raw status bit cleared while its input is still active sets again on the next clock.
- R5: With edge-select bit 1 and both-edges bit 0, the pin triggers on a rising edge when polarity is 1 and on a falling edge when it is 0. An edge of the opposite direction latches nothing.
- R6: With edge-select bit 1 and both-edges (0x24) bit 1, every transition triggers. The both-edges register exists only when VERSION is 3 or more; otherwise it reads 0 and ignores writes.
- R7: Writing the clear register (0x14) clears each raw status bit written with a 1. Bits written 0 keep their value. An event in the same cycle as its clear leaves the bit set.
- R8: Raw status (0x0C) latches events regardless of the enable register (0x08). Pending (0x10) reads raw status AND enable.
- R9: irq is a register that is 1 in the cycle after any pending bit is 1.
- R10: bus_rdata is loaded in the cycle after bus_rd and holds otherwise. Writes to raw status, pending and version are ignored. Unmapped or misaligned addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Byte address of the register |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, valid the cycle after bus_rd |
| pin_in | input | NPINS | Pad input levels, asynchronous |
| pin_out | output | NPINS | Pad output levels |
| pin_oe | output | NPINS | Pad output enables, 1 = drive |
| irq | output | 1 | Combined interrupt request |

## Verification
The assertions assume that pin_in only has to be seen through its synchronizer, so latching is tied to synchronized samples and not to raw pad levels. They also assume that bus_rd and bus_wr are plain single-cycle strobes with an aligned address. The stimulus changes pins and bus signals only on the falling clock edge and keeps every access aligned, except for one deliberate probe of an unmapped word. Pins are held steady for several cycles around each check, so that every event falls in a known cycle.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

  // Word index of each register (byte offset / 4)
  typedef enum logic [3:0] {
    RG_VAL  = 4'd0,
    RG_DIR  = 4'd1,
    RG_IEN  = 4'd2,
    RG_RAW  = 4'd3,
    RG_PEND = 4'd4,
    RG_CLR  = 4'd5,
    RG_EDGE = 4'd6,
    RG_POL  = 4'd7,
    RG_VER  = 4'd8,
    RG_BOTH = 4'd9
  } gpio_reg_e;

  // First version that implements the any-transition trigger
  localparam int BOTH_MIN_VER = 3;

endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] pin_i,
  output logic [W-1:0] sync_o,
  output logic [W-1:0] prev_o
);

  logic [W-1:0] meta_q;

  // Synchronizer flops carry no reset so they track the pads through reset.
  always_ff @(posedge clk) begin
    meta_q <= pin_i;
    sync_o <= meta_q;
    prev_o <= sync_o;
  end

  // R3
  sync_delay_chk: assert property (@(posedge clk) disable iff (rst)
    sync_o == $past(pin_i, 2));

  // R5
  prev_delay_chk: assert property (@(posedge clk) disable iff (rst)
    prev_o == $past(sync_o));

endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] sync_i,
  input  logic [W-1:0] prev_i,
  input  logic [W-1:0] edge_i,
  input  logic [W-1:0] pol_i,
  input  logic [W-1:0] both_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] status_o
);

  logic [W-1:0] hit;

  for (genvar i = 0; i < W; i++) begin : g_pin
    logic h;
    always_comb begin
      if (!edge_i[i])
        h = ~(sync_i[i] ^ pol_i[i]);
      else if (both_i[i])
        h = sync_i[i] ^ prev_i[i];
      else if (pol_i[i])
        h = sync_i[i] & ~prev_i[i];
      else
        h = ~sync_i[i] & prev_i[i];
    end
    assign hit[i] = h;
  end

  always_ff @(posedge clk) begin
    if (rst) status_o <= '0;
    else     status_o <= (status_o & ~clr_i) | hit;
  end

  // R7
  clear_only_chk: assert property (@(posedge clk) disable iff (rst)
    (($past(status_o) & ~status_o & ~$past(clr_i)) == '0));

  // R4
  level_set_chk: assert property (@(posedge clk) disable iff (rst)
    ((status_o & ~$past(status_o) & ~$past(edge_i)
      & ($past(sync_i) ^ $past(pol_i))) == '0));

  // R5
  edge_set_chk: assert property (@(posedge clk) disable iff (rst)
    ((status_o & ~$past(status_o) & $past(edge_i)
      & ~($past(sync_i) ^ $past(prev_i))) == '0));

endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
  import gpio_irq_pkg::*;
#(
  parameter int NPINS   = 32,
  parameter int ADDR_W  = 6,
  parameter int VERSION = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [31:0]       bus_wdata,
  input  logic              bus_rd,
  output logic [31:0]       bus_rdata,
  input  logic [NPINS-1:0]  pin_in,
  output logic [NPINS-1:0]  pin_out,
  output logic [NPINS-1:0]  pin_oe,
  output logic              irq
);

  localparam int IW = ADDR_W - 2;
  localparam logic [IW-1:0] I_VAL  = IW'(RG_VAL);
  localparam logic [IW-1:0] I_DIR  = IW'(RG_DIR);
  localparam logic [IW-1:0] I_IEN  = IW'(RG_IEN);
  localparam logic [IW-1:0] I_RAW  = IW'(RG_RAW);
  localparam logic [IW-1:0] I_PEND = IW'(RG_PEND);
  localparam logic [IW-1:0] I_CLR  = IW'(RG_CLR);
  localparam logic [IW-1:0] I_EDGE = IW'(RG_EDGE);
  localparam logic [IW-1:0] I_POL  = IW'(RG_POL);
  localparam logic [IW-1:0] I_VER  = IW'(RG_VER);
  localparam logic [IW-1:0] I_BOTH = IW'(RG_BOTH);

  logic [IW-1:0]    widx;
  logic             aligned;
  logic [NPINS-1:0] wd;
  logic [NPINS-1:0] val_q, ien_q, edge_q, pol_q, both_q;
  logic [NPINS-1:0] dir_view, sync_v, prev_v, status_v, clr_v, pin_view;
  logic [31:0]      rd_word;

  assign widx    = bus_addr[ADDR_W-1:2];
  assign aligned = (bus_addr[1:0] == 2'b00);
  assign wd      = bus_wdata[NPINS-1:0];

  function automatic logic wsel(input logic [IW-1:0] idx);
    return bus_wr && aligned && (widx == idx);
  endfunction

  // Control registers; pin_oe is stored directly, direction reads its inverse
  always_ff @(posedge clk) begin
    if (rst) begin
      val_q  <= '0;
      pin_oe <= '1;
      ien_q  <= '0;
      edge_q <= '0;
      pol_q  <= '0;
    end else begin
      if (wsel(I_VAL))  val_q  <= wd;
      if (wsel(I_DIR))  pin_oe <= ~wd;
      if (wsel(I_IEN))  ien_q  <= wd;
      if (wsel(I_EDGE)) edge_q <= wd;
      if (wsel(I_POL))  pol_q  <= wd;
    end
  end

  if (VERSION >= BOTH_MIN_VER) begin : g_both
    always_ff @(posedge clk) begin
      if (rst)               both_q <= '0;
      else if (wsel(I_BOTH)) both_q <= wd;
    end
  end else begin : g_no_both
    assign both_q = '0;
  end

  assign pin_out  = val_q;
  assign dir_view = ~pin_oe;
  assign clr_v    = wsel(I_CLR) ? wd : '0;
  assign pin_view = (dir_view & sync_v) | (pin_oe & val_q);

  gpio_in_sync #(.W(NPINS)) u_sync (
    .clk    (clk),
    .rst    (rst),
    .pin_i  (pin_in),
    .sync_o (sync_v),
    .prev_o (prev_v)
  );

  gpio_irq_detect #(.W(NPINS)) u_detect (
    .clk      (clk),
    .rst      (rst),
    .sync_i   (sync_v),
    .prev_i   (prev_v),
    .edge_i   (edge_q),
    .pol_i    (pol_q),
    .both_i   (both_q),
    .clr_i    (clr_v),
    .status_o (status_v)
  );

  always_comb begin
    rd_word = '0;
    if (aligned) begin
      case (widx)
        I_VAL:   rd_word = 32'(pin_view);
        I_DIR:   rd_word = 32'(dir_view);
        I_IEN:   rd_word = 32'(ien_q);
        I_RAW:   rd_word = 32'(status_v);
        I_PEND:  rd_word = 32'(status_v & ien_q);
        I_EDGE:  rd_word = 32'(edge_q);
        I_POL:   rd_word = 32'(pol_q);
        I_VER:   rd_word = 32'(VERSION);
        I_BOTH:  rd_word = 32'(both_q);
        default: rd_word = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
      irq       <= 1'b0;
    end else begin
      if (bus_rd) bus_rdata <= rd_word;
      irq <= |(status_v & ien_q);
    end
  end

  // R9
  irq_src_chk: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(|ien_q));

  // R2
  oe_write_chk: assert property (@(posedge clk) disable iff (rst)
    $past(bus_wr && aligned && widx == I_DIR) |-> pin_oe == ~$past(wd));

  // R10
  ver_read_chk: assert property (@(posedge clk) disable iff (rst)
    $past(bus_rd && aligned && widx == I_VER) |-> bus_rdata == 32'(VERSION));

endmodule

// File: tb/tb_gpio_irq_ctrl.sv
module tb_gpio_irq_ctrl;

  localparam int N  = 32;
  localparam int AW = 6;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] addr = '0;
  logic          wr = 1'b0, rd = 1'b0;
  logic [31:0]   wdata = '0;
  logic [31:0]   rdata;
  logic [N-1:0]  pin_in = '0;
  logic [N-1:0]  pin_out, pin_oe;
  logic          irq;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  gpio_irq_ctrl #(.NPINS(N), .ADDR_W(AW), .VERSION(3)) dut (
    .clk(clk), .rst(rst), .bus_addr(addr), .bus_wr(wr), .bus_wdata(wdata),
    .bus_rd(rd), .bus_rdata(rdata), .pin_in(pin_in), .pin_out(pin_out),
    .pin_oe(pin_oe), .irq(irq)
  );

  // ---------------- behavioural reference ----------------
  logic [31:0] m_val = '0, m_dir = '0, m_ien = '0, m_stat = '0;
  logic [31:0] m_edge = '0, m_pol = '0, m_both = '0, m_rdata = '0;
  logic        m_irq = 1'b0;
  logic [31:0] hist[$] = '{32'd0, 32'd0, 32'd0};

  always @(posedge clk) begin
    logic [31:0] s, p, hit, clr, rv;
    s = hist[1];
    p = hist[2];
    for (int i = 0; i < N; i++) begin
      if (!m_edge[i])     hit[i] = (s[i] == m_pol[i]);
      else if (m_both[i]) hit[i] = (s[i] != p[i]);
      else if (m_pol[i])  hit[i] = s[i] && !p[i];
      else                hit[i] = !s[i] && p[i];
    end
    if (rst) begin
      m_val = 0; m_dir = 0; m_ien = 0; m_stat = 0;
      m_edge = 0; m_pol = 0; m_both = 0; m_rdata = 0; m_irq = 0;
    end else begin
      m_irq = |(m_stat & m_ien);
      clr = (wr && addr == 6'h14) ? wdata : 32'd0;
      if (rd) begin
        case (addr)
          6'h00:   rv = (m_dir & s) | (~m_dir & m_val);
          6'h04:   rv = m_dir;
          6'h08:   rv = m_ien;
          6'h0C:   rv = m_stat;
          6'h10:   rv = m_stat & m_ien;
          6'h18:   rv = m_edge;
          6'h1C:   rv = m_pol;
          6'h20:   rv = 32'd3;
          6'h24:   rv = m_both;
          default: rv = 32'd0;
        endcase
        m_rdata = rv;
      end
      m_stat = (m_stat & ~clr) | hit;
      if (wr) begin
        case (addr)
          6'h00: m_val  = wdata;
          6'h04: m_dir  = wdata;
          6'h08: m_ien  = wdata;
          6'h18: m_edge = wdata;
          6'h1C: m_pol  = wdata;
          6'h24: m_both = wdata;
          default: ;
        endcase
      end
    end
    hist.push_front(pin_in);
    void'(hist.pop_back());
  end

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // Compare against the reference on every clock, away from the active edge
  always @(negedge clk) begin
    if (!rst) begin
      check(pin_out, m_val, "R2 pin_out vs model");
      check(pin_oe, ~m_dir, "R2 pin_oe vs model");
      check({31'd0, irq}, {31'd0, m_irq}, "R9 irq vs model");
      check(rdata, m_rdata, "R10 rdata vs model");
    end
  end

  task automatic bus_write(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic bus_read(input logic [AW-1:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    addr = a; rd = 1'b1;
    @(negedge clk);
    rd = 1'b0;
    check(rdata, exp, tag);
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  // Watchdog
  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    check(pin_oe, 32'hFFFF_FFFF, "R1 pin_oe after reset");
    check(pin_out, 32'd0, "R1 pin_out after reset");
    check({31'd0, irq}, 32'd0, "R1 irq after reset");
    bus_read(6'h04, 32'd0, "R1 direction reset");
    bus_read(6'h08, 32'd0, "R1 enable reset");
    bus_read(6'h18, 32'd0, "R1 edge reset");
    bus_read(6'h1C, 32'd0, "R1 polarity reset");
    bus_read(6'h24, 32'd0, "R1 both reset");
    bus_read(6'h00, 32'd0, "R1 value reset");
    bus_read(6'h20, 32'd3, "R1 version");

    // R2 direction and drive
    bus_write(6'h04, 32'hFFFF_0000);
    bus_write(6'h00, 32'h0000_A5A5);
    check(pin_oe, 32'h0000_FFFF, "R2 pin_oe");
    check(pin_out, 32'h0000_A5A5, "R2 pin_out");
    bus_read(6'h04, 32'hFFFF_0000, "R2 direction readback");

    // R3 mixed read of value register
    pin_in = 32'h1234_0000;
    settle();
    bus_read(6'h00, 32'h1234_A5A5, "R3 value read");

    // Edge mode, rising, everywhere; then clear everything
    bus_write(6'h18, 32'hFFFF_FFFF);
    bus_write(6'h1C, 32'hFFFF_FFFF);
    bus_write(6'h24, 32'd0);
    bus_write(6'h14, 32'hFFFF_FFFF);
    bus_read(6'h0C, 32'd0, "R7 clear all");

    // R5 rising
    pin_in = 32'h1234_0001; settle();
    bus_read(6'h0C, 32'h1, "R5 rising latched");
    pin_in = 32'h1234_0000; settle();
    bus_read(6'h0C, 32'h1, "R5 falling ignored in rising mode");
    bus_write(6'h14, 32'h1);
    bus_read(6'h0C, 32'd0, "R7 clear bit0");
    // R5 falling
    bus_write(6'h1C, 32'hFFFF_FFFE);
    pin_in = 32'h1234_0001; settle();
    bus_read(6'h0C, 32'd0, "R5 rising ignored in falling mode");
    pin_in = 32'h1234_0000; settle();
    bus_read(6'h0C, 32'h1, "R5 falling latched");
    bus_write(6'h14, 32'h1);

    // R6 both edges
    bus_write(6'h24, 32'h2);
    bus_read(6'h24, 32'h2, "R6 both readback");
    pin_in = 32'h1234_0002; settle();
    bus_read(6'h0C, 32'h2, "R6 rise in both mode");
    bus_write(6'h14, 32'h2);
    bus_read(6'h0C, 32'd0, "R6 cleared");
    pin_in = 32'h1234_0000; settle();
    bus_read(6'h0C, 32'h2, "R6 fall in both mode");

    // R7 zero bits do nothing
    bus_write(6'h14, 32'd0);
    bus_read(6'h0C, 32'h2, "R7 zero clear ignored");

    // R8 / R9 masking
    bus_read(6'h10, 32'd0, "R8 pending masked");
    check({31'd0, irq}, 32'd0, "R9 irq low while masked");
    bus_write(6'h08, 32'h2);
    repeat (2) @(negedge clk);
    bus_read(6'h10, 32'h2, "R8 pending enabled");
    check({31'd0, irq}, 32'd1, "R9 irq high");
    bus_write(6'h08, 32'd0);
    pin_in = 32'h1234_0001; settle();
    pin_in = 32'h1234_0000; settle();
    bus_read(6'h0C, 32'h3, "R8 latched while disabled");
    bus_read(6'h10, 32'd0, "R8 pending none enabled");
    bus_write(6'h08, 32'h1);
    repeat (2) @(negedge clk);
    bus_read(6'h10, 32'h1, "R8 pending after unmask");
    check({31'd0, irq}, 32'd1, "R9 irq after unmask");
    bus_write(6'h14, 32'h3);
    repeat (2) @(negedge clk);
    check({31'd0, irq}, 32'd0, "R9 irq drops after clear");

    // R4 level-high on pin 2
    bus_write(6'h18, 32'hFFFF_FFFB);
    pin_in = 32'h1234_0004; settle();
    bus_read(6'h0C, 32'h4, "R4 level high latched");
    bus_write(6'h14, 32'h4);
    bus_read(6'h0C, 32'h4, "R4 sets again while active");
    pin_in = 32'h1234_0000; settle();
    bus_write(6'h14, 32'h4);
    bus_read(6'h0C, 32'd0, "R4 cleared when inactive");

    // R10 read-only and unmapped
    bus_write(6'h0C, 32'hFFFF_FFFF);
    bus_write(6'h10, 32'hFFFF_FFFF);
    bus_write(6'h20, 32'd0);
    bus_read(6'h0C, 32'd0, "R10 raw write ignored");
    bus_read(6'h20, 32'd3, "R10 version write ignored");
    bus_read(6'h28, 32'd0, "R10 unmapped reads zero");

    repeat (3) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule